// File: doc/BRIEF.md
# Multi-core interrupt routing controller

This block gathers up to 32 level-sensitive interrupt sources and steers them onto a grid of interrupt outputs. There is one output for each pairing of a processor core with a core interrupt line. Each source passes through a two-flop synchronizer and is masked by an enable word. It is then routed by a per-source map byte. The low nibble of the map byte names the cores that receive the source. The high nibble names the interrupt lines that carry it.

An output for core c and line l rises when core c has at least one enabled, asserted source routed to it and line l has at least one such source. The two sources need not be the same one. The outputs are registered.

Software reaches the block through a small request port. One request takes one cycle. Read data returns in the following cycle. The map bytes are accessed with byte requests. Everything else takes aligned word requests. The enable word changes only through a set word and a clear word. Each core has a read-only word that shows its pending routed sources. Requests that do not follow these rules are dropped, and reads of them return zero.

Top module: `irq_route_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, all map bytes, the enable word, `irq_out` and `rsp_data` are zero.
- R2: A word read at 0x20 returns the pending word. The pending word is the input levels sampled through two flops, ANDed with the enable word. Writes to 0x20 change nothing.
- R3: A word write to 0x28 ORs the write data into the enable word. A word write to 0x2C clears each enable bit that is set in the write data. A word read at 0x24 returns the enable word.
- R4: A byte access (`req_size`=0) at offset s, for s from 0x00 to 0x1F, reads or writes the map byte of source s, using data bits 7:0. Map bits 3:0 select cores 0 to 3. Map bits 7:4 select lines 0 to 3.
- R5: `irq_out[4*c+l]` is 1 exactly when some pending source maps to core c and some pending source, possibly a different one, maps to line l.
- R6: `irq_out` is registered. An input change appears on it at the third rising edge after the change. A write to the map or the enable word appears at the second rising edge after the write is issued.
- R7: A word read at 0x40+8*c returns the pending sources mapped to core c. Word 0x44+8*c mirrors the same value. Writes to these words have no effect.
- R8: An access whose size field is 1 or 3, a word access that is not 4-byte aligned, a word access to the map region, or a byte access above 0x1F is ignored. A read of any of these returns zero.
- R9: Aligned word accesses to any other offset (0x24 written, 0x30, 0x60 to 0x7F) are ignored, and reads of them return zero. The enable word changes only through 0x28 and 0x2C.
- R10: Read data appears on `rsp_data` in the cycle after the read request. In every cycle that follows no read request, `rsp_data` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| irq_in | input | NUM_SRC | Level interrupt sources, asynchronous |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 half, 2 word, 3 reserved |
| req_addr | input | 7 | Byte offset in the register window |
| req_wdata | input | 32 | Write data |
| rsp_data | output | 32 | Read data, one cycle after the read request |
| irq_out | output | NUM_CORE*NUM_LINE | Routed interrupt outputs, index 4*core+line |

## Verification
The bench builds the block with its default values: 32 sources, 4 cores and 4 lines. This makes the top map byte at 0x1F, source bit 31, the full 0x40 to 0x5F per-core window with its mirror words, and all 16 outputs reachable. A behavioural model follows the bus and the pins on every edge and compares both outputs each cycle. Directed cases add a routing pattern in which the cross-source rule and a per-source rule give different outputs, the three-edge input latency, and every kind of rejected access.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int BUS_W     = 32;
  localparam int ADDR_W    = 7;
  localparam int MAP_SLOTS = 32;

  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_HALF = 2'd1,
    ACC_WORD = 2'd2,
    ACC_RSVD = 2'd3
  } acc_size_e;

  localparam logic [ADDR_W-1:0] A_STATUS  = 7'h20;
  localparam logic [ADDR_W-1:0] A_EN_VIEW = 7'h24;
  localparam logic [ADDR_W-1:0] A_EN_SET  = 7'h28;
  localparam logic [ADDR_W-1:0] A_EN_CLR  = 7'h2C;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      hold_q <= '0;
    end else begin
      meta_q <= d;
      hold_q <= meta_q;
    end
  end

  assign q = hold_q;
endmodule

// File: rtl/irq_regs.sv
module irq_regs #(
  parameter int NUM_SRC = 32,
  parameter int MAP_W   = 8,
  parameter int IDX_W   = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     map_we,
  input  logic [IDX_W-1:0]         map_idx,
  input  logic [MAP_W-1:0]         map_wdata,
  input  logic                     en_set,
  input  logic                     en_clr,
  input  logic [NUM_SRC-1:0]       en_wdata,
  output logic [NUM_SRC*MAP_W-1:0] map_flat,
  output logic [NUM_SRC-1:0]       ien
);
  logic [NUM_SRC-1:0] ien_q;
  logic [NUM_SRC-1:0] ien_d;
  logic               ien_ce;

  always_comb begin
    ien_d = ien_q;
    if (en_set) ien_d = ien_d | en_wdata;
    if (en_clr) ien_d = ien_d & ~en_wdata;
  end

  assign ien_ce = en_set | en_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ien_q <= '0;
    else if (ien_ce) ien_q <= ien_d;
  end

  assign ien = ien_q;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_entry
    logic [MAP_W-1:0] ent_q;
    logic             ent_ce;

    assign ent_ce = map_we && (map_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q <= '0;
      else if (ent_ce) ent_q <= map_wdata;
    end

    assign map_flat[g*MAP_W +: MAP_W] = ent_q;
  end
endmodule

// File: rtl/irq_route.sv
module irq_route #(
  parameter int NUM_SRC  = 32,
  parameter int NUM_CORE = 4,
  parameter int NUM_LINE = 4
) (
  input  logic [NUM_SRC-1:0]                      pend,
  input  logic [NUM_SRC*(NUM_CORE+NUM_LINE)-1:0]  map_flat,
  output logic [NUM_CORE*NUM_SRC-1:0]             core_pend,
  output logic [NUM_CORE*NUM_LINE-1:0]            route
);
  localparam int MAP_W = NUM_CORE + NUM_LINE;

  logic [NUM_CORE-1:0] core_any;
  logic [NUM_LINE-1:0] line_any;

  for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      assign core_pend[c*NUM_SRC+s] = pend[s] & map_flat[s*MAP_W+c];
    end
    assign core_any[c] = |core_pend[c*NUM_SRC +: NUM_SRC];
  end

  for (genvar l = 0; l < NUM_LINE; l++) begin : g_line
    logic [NUM_SRC-1:0] line_pend;
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      assign line_pend[s] = pend[s] & map_flat[s*MAP_W+NUM_CORE+l];
    end
    assign line_any[l] = |line_pend;
  end

  for (genvar c = 0; c < NUM_CORE; c++) begin : g_out_c
    for (genvar l = 0; l < NUM_LINE; l++) begin : g_out_l
      assign route[c*NUM_LINE+l] = core_any[c] & line_any[l];
    end
  end
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_CORE = 4,
  parameter int NUM_LINE = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_SRC-1:0]           irq_in,
  input  logic                         req_valid,
  input  logic                         req_write,
  input  logic [1:0]                   req_size,
  input  logic [ADDR_W-1:0]            req_addr,
  input  logic [BUS_W-1:0]             req_wdata,
  output logic [BUS_W-1:0]             rsp_data,
  output logic [NUM_CORE*NUM_LINE-1:0] irq_out
);
  localparam int MAP_W   = NUM_CORE + NUM_LINE;
  localparam int IDX_W   = $clog2(MAP_SLOTS);
  localparam int NUM_OUT = NUM_CORE * NUM_LINE;

  acc_size_e               acc_sz;
  logic                    is_byte;
  logic                    is_word;
  logic [IDX_W-1:0]        map_idx;
  logic [1:0]              core_sel;
  logic                    in_map;
  logic                    in_core;
  logic                    do_wr;
  logic                    do_rd;
  logic                    map_we;
  logic                    en_set;
  logic                    en_clr;

  logic [NUM_SRC-1:0]       sync_w;
  logic [NUM_SRC-1:0]       ien_q;
  logic [NUM_SRC-1:0]       status_w;
  logic [NUM_SRC*MAP_W-1:0] map_flat;
  logic [NUM_CORE*NUM_SRC-1:0] core_pend;
  logic [NUM_OUT-1:0]       route_w;

  logic [BUS_W-1:0]         rd_val;
  logic [BUS_W-1:0]         rsp_d;
  logic [BUS_W-1:0]         rsp_q;
  logic [NUM_OUT-1:0]       irq_q;
  logic                     irq_ce;

  // request decode
  assign acc_sz   = acc_size_e'(req_size);
  assign is_byte  = (acc_sz == ACC_BYTE);
  assign is_word  = (acc_sz == ACC_WORD) && (req_addr[1:0] == 2'b00);
  assign map_idx  = req_addr[IDX_W-1:0];
  assign core_sel = req_addr[4:3];
  assign in_map   = is_byte && (req_addr[ADDR_W-1:IDX_W] == '0)
                    && (32'(map_idx) < 32'(NUM_SRC));
  assign in_core  = is_word && (req_addr[6:5] == 2'b10)
                    && (32'(core_sel) < 32'(NUM_CORE));
  assign do_wr    = req_valid && req_write;
  assign do_rd    = req_valid && !req_write;
  assign map_we   = do_wr && in_map;
  assign en_set   = do_wr && is_word && (req_addr == A_EN_SET);
  assign en_clr   = do_wr && is_word && (req_addr == A_EN_CLR);

  irq_sync #(.W(NUM_SRC)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (irq_in),
    .q     (sync_w)
  );

  irq_regs #(.NUM_SRC(NUM_SRC), .MAP_W(MAP_W), .IDX_W(IDX_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .map_we    (map_we),
    .map_idx   (map_idx),
    .map_wdata (req_wdata[MAP_W-1:0]),
    .en_set    (en_set),
    .en_clr    (en_clr),
    .en_wdata  (req_wdata[NUM_SRC-1:0]),
    .map_flat  (map_flat),
    .ien       (ien_q)
  );

  assign status_w = sync_w & ien_q;

  irq_route #(.NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE), .NUM_LINE(NUM_LINE)) u_route (
    .pend      (status_w),
    .map_flat  (map_flat),
    .core_pend (core_pend),
    .route     (route_w)
  );

  // read selection
  always_comb begin
    rd_val = '0;
    if (in_map) begin
      rd_val[MAP_W-1:0] = map_flat[map_idx*MAP_W +: MAP_W];
    end else if (in_core) begin
      rd_val[NUM_SRC-1:0] = core_pend[core_sel*NUM_SRC +: NUM_SRC];
    end else if (is_word) begin
      case (req_addr)
        A_STATUS:  rd_val[NUM_SRC-1:0] = status_w;
        A_EN_VIEW: rd_val[NUM_SRC-1:0] = ien_q;
        default:   rd_val = '0;
      endcase
    end
  end

  assign rsp_d  = do_rd ? rd_val : '0;
  assign irq_ce = (route_w != irq_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_q <= '0;
    else        rsp_q <= rsp_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq_q <= '0;
    else if (irq_ce) irq_q <= route_w;
  end

  assign rsp_data = rsp_q;
  assign irq_out  = irq_q;
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
  parameter int NUM_SRC  = 32,
  parameter int NUM_OUT  = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_write,
  input logic [1:0]         req_size,
  input logic [6:0]         req_addr,
  input logic [31:0]        req_wdata,
  input logic [31:0]        rsp_data,
  input logic [NUM_OUT-1:0] irq_out,
  input logic [NUM_SRC-1:0] ien,
  input logic [NUM_SRC-1:0] status
);
  logic is_set;
  logic is_clr;

  assign is_set = req_valid && req_write && (req_size == 2'd2) && (req_addr == 7'h28);
  assign is_clr = req_valid && req_write && (req_size == 2'd2) && (req_addr == 7'h2C);

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_CLEARS: assert (irq_out == '0 && ien == '0 && rsp_data == '0); // R1
    end
  end

  AST_IDLE_RSP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> (rsp_data == '0)); // R10

  AST_HALF_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_size == 2'd1) |=> (rsp_data == '0)); // R8

  AST_MISALIGNED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_size == 2'd2 && req_addr[1:0] != 2'b00)
    |=> (rsp_data == '0)); // R8

  AST_EN_SET_ORS: assert property (@(posedge clk) disable iff (!rst_n)
    is_set |=> (((ien & $past(req_wdata[NUM_SRC-1:0])) == $past(req_wdata[NUM_SRC-1:0]))
               && (($past(ien) & ~ien) == '0))); // R3

  AST_EN_CLR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    is_clr |=> (((ien & $past(req_wdata[NUM_SRC-1:0])) == '0)
               && ((ien & ~$past(ien)) == '0))); // R3

  AST_EN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(is_set || is_clr) |=> $stable(ien)); // R9

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (status == '0) |=> (irq_out == '0)); // R5
endmodule

bind irq_route_ctrl irq_route_chk #(
  .NUM_SRC (NUM_SRC),
  .NUM_OUT (NUM_CORE*NUM_LINE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_size  (req_size),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .rsp_data  (rsp_data),
  .irq_out   (irq_out),
  .ien       (ien_q),
  .status    (status_w)
);

// File: tb/sim_irq_route_ctrl.sv
module sim_irq_route_ctrl;
  localparam int CLK_P = 10;
  localparam int NS = 32;
  localparam int NC = 4;
  localparam int NL = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] irq_in;
  logic        req_valid;
  logic        req_write;
  logic [1:0]  req_size;
  logic [6:0]  req_addr;
  logic [31:0] req_wdata;
  logic [31:0] rsp_data;
  logic [15:0] irq_out;

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;
  string cur_tag = "R1";

  irq_route_ctrl #(.NUM_SRC(NS), .NUM_CORE(NC), .NUM_LINE(NL)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .req_valid(req_valid),
    .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_data(rsp_data), .irq_out(irq_out)
  );

  always #(CLK_P/2) clk = ~clk;

  // behavioural reference model
  logic [31:0] m_s1, m_s2, m_ien, m_rsp;
  logic [7:0]  m_map [32];
  logic [15:0] m_out;

  function automatic logic [31:0] m_pend();
    return m_s2 & m_ien;
  endfunction

  function automatic logic [31:0] m_core_word(int c);
    logic [31:0] p = m_pend();
    logic [31:0] r = '0;
    for (int s = 0; s < NS; s++) if (p[s] && m_map[s][c]) r[s] = 1'b1;
    return r;
  endfunction

  function automatic logic [15:0] m_route();
    logic [31:0] p = m_pend();
    logic [15:0] r = '0;
    for (int c = 0; c < NC; c++)
      for (int l = 0; l < NL; l++) begin
        bit hc = 0, hl = 0;
        for (int s = 0; s < NS; s++) begin
          if (p[s] && m_map[s][c])      hc = 1;
          if (p[s] && m_map[s][NC + l]) hl = 1;
        end
        r[c*NL + l] = hc && hl;
      end
    return r;
  endfunction

  function automatic logic [31:0] m_read(int a, int sz);
    if (sz == 0 && a < 32) return {24'b0, m_map[a]};
    if (sz != 2 || (a % 4) != 0) return '0;
    if (a >= 'h40 && a < 'h60) return m_core_word((a - 'h40) / 8);
    if (a == 'h20) return m_pend();
    if (a == 'h24) return m_ien;
    return '0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_ien = '0; m_rsp = '0; m_out = '0;
      for (int s = 0; s < 32; s++) m_map[s] = '0;
    end else begin
      logic [15:0] n_out;
      logic [31:0] n_rsp;
      int a, sz;
      a = int'(req_addr);
      sz = int'(req_size);
      n_out = m_route();
      n_rsp = (req_valid && !req_write) ? m_read(a, sz) : '0;
      if (req_valid && req_write) begin
        if (sz == 0 && a < 32) m_map[a] = req_wdata[7:0];
        else if (sz == 2 && a == 'h28) m_ien = m_ien | req_wdata;
        else if (sz == 2 && a == 'h2C) m_ien = m_ien & ~req_wdata;
      end
      m_s2 = m_s1;
      m_s1 = irq_in;
      m_out = n_out;
      m_rsp = n_rsp;
    end
  end

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      chk("R5", "irq_out vs model", {16'b0, irq_out}, {16'b0, m_out});
      chk(cur_tag, "rsp_data vs model", rsp_data, m_rsp);
    end
  end

  task automatic bus_wr(int a, int sz, logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 7'(a);
    req_size = 2'(sz); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd_chk(string tag, int a, int sz, logic [31:0] exp);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 7'(a);
    req_size = 2'(sz); req_wdata = '0;
    @(negedge clk);
    chk(tag, $sformatf("read a=%0h sz=%0d", a, sz), rsp_data, exp);
    req_valid = 1'b0;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog run hung actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b1; irq_in = '0; req_valid = 0; req_write = 0;
    req_size = 0; req_addr = 0; req_wdata = 0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "irq_out in reset", {16'b0, irq_out}, '0);
    chk("R1", "rsp_data in reset", rsp_data, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: state after reset
    cur_tag = "R1";
    rd_chk("R1", 'h24, 2, 32'h0);
    rd_chk("R1", 'h1F, 0, 32'h0);
    chk("R1", "irq_out after reset", {16'b0, irq_out}, '0);

    // R4: map bytes
    cur_tag = "R4";
    bus_wr('h03, 0, 32'hFFFF_FF21);
    rd_chk("R4", 'h03, 0, 32'h21);
    bus_wr('h1F, 0, 32'h0000_00C4);
    rd_chk("R4", 'h1F, 0, 32'hC4);

    // R3 and R9: enable set / clear / view
    cur_tag = "R3";
    bus_wr('h28, 2, 32'h0000_0009);
    bus_wr('h28, 2, 32'h8000_0010);
    rd_chk("R3", 'h24, 2, 32'h8000_0019);
    bus_wr('h2C, 2, 32'h0000_0001);
    rd_chk("R3", 'h24, 2, 32'h8000_0018);
    cur_tag = "R9";
    bus_wr('h24, 2, 32'hFFFF_FFFF);
    rd_chk("R9", 'h24, 2, 32'h8000_0018);
    bus_wr('h20, 2, 32'hFFFF_FFFF);
    rd_chk("R9", 'h30, 2, 32'h0);
    rd_chk("R9", 'h60, 2, 32'h0);
    rd_chk("R9", 'h7C, 2, 32'h0);

    // R6 latency and R5 cross-source routing
    cur_tag = "R6";
    irq_in = 32'h8000_0008;
    @(negedge clk);
    chk("R6", "irq_out after 1 edge", {16'b0, irq_out}, 32'h0);
    @(negedge clk);
    chk("R6", "irq_out after 2 edges", {16'b0, irq_out}, 32'h0);
    @(negedge clk);
    chk("R5", "cross-source routing", {16'b0, irq_out}, 32'h0000_0E0E);

    // R2 and R7: pending and per-core words
    cur_tag = "R2";
    rd_chk("R2", 'h20, 2, 32'h8000_0008);
    cur_tag = "R7";
    rd_chk("R7", 'h40, 2, 32'h0000_0008);
    rd_chk("R7", 'h48, 2, 32'h0);
    rd_chk("R7", 'h50, 2, 32'h8000_0000);
    rd_chk("R7", 'h54, 2, 32'h8000_0000);
    bus_wr('h40, 2, 32'hFFFF_FFFF);
    rd_chk("R7", 'h40, 2, 32'h0000_0008);

    // R8: rejected accesses
    cur_tag = "R8";
    rd_chk("R8", 'h24, 1, 32'h0);
    rd_chk("R8", 'h24, 3, 32'h0);
    rd_chk("R8", 'h00, 2, 32'h0);
    rd_chk("R8", 'h24, 0, 32'h0);
    rd_chk("R8", 'h26, 2, 32'h0);
    bus_wr('h28, 0, 32'hFFFF_FFFF);
    bus_wr('h29, 2, 32'hFFFF_FFFF);
    rd_chk("R8", 'h24, 2, 32'h8000_0018);
    bus_wr('h04, 2, 32'hFFFF_FFFF);
    rd_chk("R8", 'h04, 0, 32'h0);
    bus_wr('h03, 1, 32'h0);
    rd_chk("R8", 'h03, 0, 32'h21);

    // R10: read data only in the cycle after the request
    cur_tag = "R10";
    rd_chk("R10", 'h03, 0, 32'h21);
    @(negedge clk);
    chk("R10", "rsp_data idle", rsp_data, 32'h0);

    // R6: write-to-output latency, R5 with masking
    cur_tag = "R6";
    bus_wr('h2C, 2, 32'h8000_0000);
    chk("R6", "irq_out one edge after clear", {16'b0, irq_out}, 32'h0000_0E0E);
    @(negedge clk);
    chk("R5", "routing after mask", {16'b0, irq_out}, 32'h0000_0002);
    rd_chk("R2", 'h20, 2, 32'h0000_0008);

    // random phase against the model
    cur_tag = "R8";
    for (int i = 0; i < 600; i++) begin
      int k;
      if (($urandom % 4) == 0) irq_in = $urandom;
      req_valid = ($urandom % 2) == 1;
      req_write = ($urandom % 2) == 1;
      k = $urandom % 8;
      req_size = (k < 3) ? 2'd0 : (k < 7) ? 2'd2 : 2'($urandom);
      case ($urandom % 6)
        0: req_addr = 7'($urandom % 32);
        1: req_addr = 7'h20;
        2: req_addr = 7'h24;
        3: req_addr = (($urandom % 3) == 0) ? 7'h2C : 7'h28;
        4: req_addr = 7'h40 + 7'($urandom % 32);
        default: req_addr = 7'($urandom);
      endcase
      req_wdata = $urandom;
      @(negedge clk);
    end
    req_valid = 1'b0;
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule